// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block turns a single host strobe into the full chain of byte transfers that a serial EEPROM needs for one byte read or one byte write. It sits next to a plain byte-wide SPI shift engine: it owns the active-low chip select, hands the engine one byte at a time with a start pulse, and waits for the engine's completion flag before it moves on. The engine returns the byte it shifted in, and the sequencer keeps the bytes it needs.

A write is carried out in three phases, each in its own chip-select frame. First the device's status is read and checked, and the sequencer repeats this until the device reports that no internal write is running. Next comes a one-byte frame that arms the device for writing. Last comes the write frame with the opcode, the address (most significant byte first) and the data. A read is a single frame with no polling. Its last byte is a dummy zero, and the byte shifted in during that dummy becomes the result. A programmable number of guard clocks separates every chip-select edge from the neighbouring byte transfers and from the next frame.

The host sees `busy` while a transaction runs and a one-cycle `done` when it ends. For a read, `rdData` holds the fetched byte from `done` until the next read completes.

Top module: `spi_eeprom_sequencer`

## Requirements
- R1: Out of reset, and whenever the block is idle, `csN` is high and `busy`, `done` and `shStart` are low.
- R2: A write first runs status frames of exactly two bytes, 0x05 then 0x00. A new status frame follows as long as bit 0 of the byte returned during the 0x00 byte is 1. The first frame that returns bit 0 clear ends polling.
- R3: After polling ends, the block sends a frame holding only the byte 0x06. Chip select goes high after that byte, and only then does the write frame begin.
- R4: The write frame is 0x02, address bits 15:8, address bits 7:0, then the data byte, all in one chip-select low period.
- R5: A read is one frame, 0x03, address bits 15:8, address bits 7:0, 0x00, with no status polling before it. `rdData` equals the byte returned during the 0x00 byte once `done` is seen.
- R6: `shStart` is a one-cycle pulse given only while `csN` is low and only after the previous byte's `shDone`. `shTxByte` stays unchanged while a transfer is outstanding.
- R7: With GUARD guard clocks: `csN` is low for at least GUARD cycles before the first `shStart` of a frame. At least GUARD cycles pass after the last `shDone` before `csN` rises. `csN` stays high for at least GUARD cycles between frames.
- R8: A read or write strobe that arrives while `busy` is high has no effect. It causes no frame, and it changes neither the memory contents nor `rdData`.
- R9: `done` is high for exactly one cycle, with `csN` high. `busy` is high from the cycle after the request is accepted until the cycle after `done`.
- R10: If read and write strobes arrive together while idle, the block performs the write and ignores the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRead | input | 1 | Start a one-byte read (sampled while idle) |
| reqWrite | input | 1 | Start a one-byte write (sampled while idle, wins over read) |
| reqAddr | input | ADDR_W | Device byte address |
| reqData | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdData | output | 8 | Byte fetched by the last read |
| csN | output | 1 | Device chip select, active low |
| shStart | output | 1 | Start pulse to the shift engine |
| shTxByte | output | 8 | Byte for the shift engine to send |
| shDone | input | 1 | Shift engine transfer-complete flag |
| shRxByte | input | 8 | Byte the shift engine received |

## Verification
The bound checker checks the handshake and timing rules on every cycle: start pulses that do not overlap and fall only inside a frame, a held transmit byte, the three guard intervals around chip-select edges, a one-cycle done with chip select high, and a high chip select while idle. Frame contents can only be shown by the bench scenarios. These include the number of status polls for several device busy lengths, the arming frame standing apart from the write frame, the address byte order and the read data path. The same holds for strobes ignored while busy and for the write winning when both strobes arrive together. The bench shows these with a device model and a queue of expected frames.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam int         BUSY_BIT  = 0;

  typedef enum logic [1:0] {
    K_POLL  = 2'd0,
    K_ARM   = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } kind_t;

  typedef struct packed {
    logic  loadReq;
    logic  clrIdx;
    logic  incIdx;
    logic  capture;
    kind_t kind;
  } seqCmd_t;

  function automatic logic [7:0] opcodeOf(kind_t k);
    case (k)
      K_POLL:  return OP_STATUS;
      K_ARM:   return OP_ARM;
      K_WRITE: return OP_WRITE;
      default: return OP_READ;
    endcase
  endfunction

  function automatic int frameBytes(kind_t k, int addrBytes);
    case (k)
      K_POLL:  return 2;
      K_ARM:   return 1;
      default: return addrBytes + 2;
    endcase
  endfunction

endpackage

// File: rtl/eeseq_dpath.sv
module eeseq_dpath
  import eeseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        shRxByte,
  output logic [7:0]        shTxByte,
  output logic [7:0]        rdData,
  output logic              lastByte,
  output logic              devBusy
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 2);

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic [IDX_W-1:0]  idxQ;
  logic              statusQ;
  logic [7:0]        rdQ;
  logic [7:0]        addrByte [ADDR_BYTES];

  // address bytes, most significant first
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gAddrByte
    assign addrByte[g] = addrQ[(ADDR_BYTES-1-g)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      idxQ    <= '0;
      statusQ <= 1'b0;
      rdQ     <= '0;
    end else begin
      if (cmd.loadReq) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
      end
      if (cmd.clrIdx)      idxQ <= '0;
      else if (cmd.incIdx) idxQ <= idxQ + 1'b1;
      if (cmd.capture) begin
        if (cmd.kind == K_POLL) statusQ <= shRxByte[BUSY_BIT];
        if (cmd.kind == K_READ) rdQ     <= shRxByte;
      end
    end
  end

  always_comb begin
    shTxByte = FILL_BYTE;
    if (idxQ == '0) begin
      shTxByte = opcodeOf(cmd.kind);
    end else if (cmd.kind == K_WRITE || cmd.kind == K_READ) begin
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (idxQ == IDX_W'(b + 1)) shTxByte = addrByte[b];
      end
      if (cmd.kind == K_WRITE && idxQ == IDX_W'(ADDR_BYTES + 1)) shTxByte = dataQ;
    end
  end

  assign lastByte = (idxQ == IDX_W'(frameBytes(cmd.kind, ADDR_BYTES) - 1));
  assign devBusy  = statusQ;
  assign rdData   = rdQ;

endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
#(
  parameter int GUARD = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqRead,
  input  logic    reqWrite,
  input  logic    lastByte,
  input  logic    devBusy,
  input  logic    shDone,
  output seqCmd_t cmd,
  output logic    shStart,
  output logic    csN,
  output logic    busy,
  output logic    done
);

  localparam int CW = $clog2(GUARD + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_ISSUE, S_WAIT, S_TAIL, S_GAP, S_DONE
  } state_t;

  state_t          stQ, stD;
  kind_t           kindQ, kindD;
  logic [CW-1:0]   cntQ;
  logic            inGuard;
  logic            guardEnd;

  assign inGuard  = (stQ == S_LEAD) || (stQ == S_TAIL) || (stQ == S_GAP);
  assign guardEnd = inGuard && (cntQ == CW'(GUARD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= S_IDLE;
      kindQ <= K_POLL;
      cntQ  <= '0;
    end else begin
      stQ   <= stD;
      kindQ <= kindD;
      cntQ  <= (!inGuard || guardEnd) ? '0 : cntQ + 1'b1;
    end
  end

  always_comb begin
    stD         = stQ;
    kindD       = kindQ;
    cmd.loadReq = 1'b0;
    cmd.clrIdx  = 1'b0;
    cmd.incIdx  = 1'b0;
    cmd.capture = 1'b0;
    cmd.kind    = kindQ;
    case (stQ)
      S_IDLE: begin
        if (reqWrite) begin
          cmd.loadReq = 1'b1;
          cmd.clrIdx  = 1'b1;
          kindD       = K_POLL;
          stD         = S_LEAD;
        end else if (reqRead) begin
          cmd.loadReq = 1'b1;
          cmd.clrIdx  = 1'b1;
          kindD       = K_READ;
          stD         = S_LEAD;
        end
      end
      S_LEAD:  if (guardEnd) stD = S_ISSUE;
      S_ISSUE: stD = S_WAIT;
      S_WAIT: begin
        if (shDone) begin
          if (lastByte) begin
            cmd.capture = 1'b1;
            stD         = S_TAIL;
          end else begin
            cmd.incIdx = 1'b1;
            stD        = S_ISSUE;
          end
        end
      end
      S_TAIL:  if (guardEnd) stD = S_GAP;
      S_GAP: begin
        if (guardEnd) begin
          cmd.clrIdx = 1'b1;
          case (kindQ)
            K_POLL: begin
              kindD = devBusy ? K_POLL : K_ARM;
              stD   = S_LEAD;
            end
            K_ARM: begin
              kindD = K_WRITE;
              stD   = S_LEAD;
            end
            default: stD = S_DONE;
          endcase
        end
      end
      S_DONE:  stD = S_IDLE;
      default: stD = S_IDLE;
    endcase
  end

  assign shStart = (stQ == S_ISSUE);
  assign csN     = !((stQ == S_LEAD) || (stQ == S_ISSUE) || (stQ == S_WAIT) || (stQ == S_TAIL));
  assign busy    = (stQ != S_IDLE);
  assign done    = (stQ == S_DONE);

endmodule

// File: rtl/spi_eeprom_sequencer.sv
module spi_eeprom_sequencer
  import eeseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GUARD  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdData,
  output logic              csN,
  output logic              shStart,
  output logic [7:0]        shTxByte,
  input  logic              shDone,
  input  logic [7:0]        shRxByte
);

  seqCmd_t cmd;
  logic    lastByte;
  logic    devBusy;

  eeseq_ctrl #(.GUARD(GUARD)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqRead  (reqRead),
    .reqWrite (reqWrite),
    .lastByte (lastByte),
    .devBusy  (devBusy),
    .shDone   (shDone),
    .cmd      (cmd),
    .shStart  (shStart),
    .csN      (csN),
    .busy     (busy),
    .done     (done)
  );

  eeseq_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .shRxByte (shRxByte),
    .shTxByte (shTxByte),
    .rdData   (rdData),
    .lastByte (lastByte),
    .devBusy  (devBusy)
  );

endmodule

// File: rtl/eeseq_checker.sv
module eeseq_checker #(
  parameter int GUARD = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       csN,
  input logic       shStart,
  input logic [7:0] shTxByte,
  input logic       shDone
);

  logic        outstanding;
  logic [15:0] lowCnt;
  logic [15:0] highCnt;
  logic [15:0] sinceDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      lowCnt      <= '0;
      highCnt     <= 16'hFFFF;
      sinceDone   <= 16'hFFFF;
    end else begin
      if (shStart)     outstanding <= 1'b1;
      else if (shDone) outstanding <= 1'b0;
      lowCnt    <= csN ? '0 : ((lowCnt == 16'hFFFF) ? lowCnt : lowCnt + 1'b1);
      highCnt   <= !csN ? '0 : ((highCnt == 16'hFFFF) ? highCnt : highCnt + 1'b1);
      sinceDone <= shDone ? '0 : ((sinceDone == 16'hFFFF) ? sinceDone : sinceDone + 1'b1);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !shStart && !done));

  a_r6_start_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    shStart |-> !csN);

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    shStart |-> !outstanding);

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    shStart |=> !shStart);

  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> $stable(shTxByte));

  a_r7_lead_guard: assert property (@(posedge clk) disable iff (!rstN)
    shStart |-> (lowCnt >= 16'(GUARD)));

  a_r7_tail_guard: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (sinceDone >= 16'(GUARD)));

  a_r7_frame_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= 16'(GUARD)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && busy && !outstanding));

endmodule

bind spi_eeprom_sequencer eeseq_checker #(.GUARD(GUARD)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .csN      (csN),
  .shStart  (shStart),
  .shTxByte (shTxByte),
  .shDone   (shDone)
);

// File: tb/spi_eeprom_sequencer_test.sv
module spi_eeprom_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 4;
  localparam int ADDR_W     = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqRead, reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0]        reqData;
  logic              busy, done, csN, shStart, shDone;
  logic [7:0]        rdData, shTxByte, shRxByte;

  spi_eeprom_sequencer #(.ADDR_W(ADDR_W), .GUARD(GUARD)) uut (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .rdData(rdData), .csN(csN), .shStart(shStart), .shTxByte(shTxByte),
    .shDone(shDone), .shRxByte(shRxByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected frames: {length, byte0..byte3}
  logic [39:0] expQ[$];

  function automatic logic [39:0] pk(input int n, input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] c, input logic [7:0] d);
    return {8'(n), a, b, c, d};
  endfunction

  // device model state
  logic [7:0] mem[int];
  logic       wel;
  int         busyLeft, busyCfg;
  logic [7:0] fr[$];
  int         latCnt, xferNo, doneCycle, lowRun, highRun, framesSinceDone;
  logic       inXfer, prevCs;
  logic [7:0] pendRx;

  // device responder and frame monitor, all at the falling edge
  initial begin
    shDone = 1'b0; shRxByte = 8'h00; wel = 1'b0; busyLeft = 0; busyCfg = 0;
    latCnt = 0; xferNo = 0; doneCycle = 0; lowRun = 0; highRun = 0;
    framesSinceDone = 0; inXfer = 1'b0; prevCs = 1'b1; pendRx = 8'h00;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1) begin
        shDone = 1'b0;
        if (latCnt > 0) begin
          latCnt--;
          if (latCnt == 0) begin
            shDone = 1'b1; shRxByte = pendRx; doneCycle = cyc; inXfer = 1'b0;
          end
        end
        if (!csN && prevCs) begin
          if (framesSinceDone > 0)
            check(highRun >= GUARD, "R7", "csN high gap between frames", highRun, GUARD);
          fr.delete();
        end
        if (csN && !prevCs) begin
          logic [39:0] act;
          check(cyc - doneCycle >= GUARD + 1, "R7", "tail guard before csN rise",
                cyc - doneCycle, GUARD + 1);
          act = pk(fr.size(), fr.size() > 0 ? fr[0] : 8'h0, fr.size() > 1 ? fr[1] : 8'h0,
                   fr.size() > 2 ? fr[2] : 8'h0, fr.size() > 3 ? fr[3] : 8'h0);
          if (expQ.size() == 0) begin
            check(1'b0, "R8", "unexpected frame", act, 0);
          end else begin
            logic [39:0] exp;
            string tag;
            exp = expQ.pop_front();
            case (exp[31:24])
              8'h05:   tag = "R2";
              8'h06:   tag = "R3";
              8'h02:   tag = "R4";
              default: tag = "R5";
            endcase
            check(act == exp, tag, "frame contents", act, exp);
          end
          if (fr.size() == 2 && fr[0] == 8'h05 && busyLeft > 0) busyLeft--;
          if (fr.size() == 1 && fr[0] == 8'h06) wel = 1'b1;
          if (fr.size() == 4 && fr[0] == 8'h02 && wel) begin
            mem[{fr[1], fr[2]}] = fr[3]; wel = 1'b0; busyLeft = busyCfg;
          end
          framesSinceDone++;
        end
        if (!csN) begin lowRun++; highRun = 0; end
        else begin highRun++; lowRun = 0; end
        prevCs = csN;
        if (done) framesSinceDone = 0;
        if (shStart) begin
          int idx;
          check(!inXfer, "R6", "start while transfer outstanding", inXfer, 0);
          check(!csN, "R6", "start outside frame", csN, 0);
          if (fr.size() == 0)
            check(lowRun >= GUARD + 1, "R7", "lead guard after csN fall", lowRun, GUARD + 1);
          idx = fr.size();
          fr.push_back(shTxByte);
          pendRx = 8'hA5;
          if (fr[0] == 8'h05 && idx == 1) pendRx = {7'b0, busyLeft > 0};
          if (fr[0] == 8'h03 && idx == 3) begin
            int a;
            a = {fr[1], fr[2]};
            pendRx = mem.exists(a) ? mem[a] : 8'hFF;
          end
          latCnt = 1 + (xferNo % 4);
          xferNo++;
          inXfer = 1'b1;
        end
      end
    end
  end

  int expBusy = 0;

  task automatic pushWriteFrames(input logic [15:0] a, input logic [7:0] d, input int nextBusy);
    for (int i = 0; i <= expBusy; i++) expQ.push_back(pk(2, 8'h05, 8'h00, 8'h00, 8'h00));
    expQ.push_back(pk(1, 8'h06, 8'h00, 8'h00, 8'h00));
    expQ.push_back(pk(4, 8'h02, a[15:8], a[7:0], d));
    expBusy = nextBusy;
    busyCfg = nextBusy;
  endtask

  task automatic pulseReq(input logic r, input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reqRead = r; reqWrite = w; reqAddr = a; reqData = d;
    @(negedge clk);
    reqRead = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done, "R9", {req, " done seen"}, done, 1);
    check(csN, "R9", "csN high at done", csN, 1);
  endtask

  task automatic afterDone();
    @(negedge clk);
    check(!done, "R9", "done lasts one cycle", done, 0);
    check(!busy, "R9", "busy low after done", busy, 0);
    check(csN, "R1", "csN high when idle", csN, 1);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, input int nextBusy);
    pushWriteFrames(a, d, nextBusy);
    pulseReq(1'b0, 1'b1, a, d);
    check(busy, "R9", "busy after accept", busy, 1);
    waitDone("R4 write");
    afterDone();
  endtask

  task automatic doRead(input logic [15:0] a, input logic [7:0] expData);
    expQ.push_back(pk(4, 8'h03, a[15:8], a[7:0], 8'h00));
    pulseReq(1'b1, 1'b0, a, 8'h00);
    check(busy, "R9", "busy after accept", busy, 1);
    waitDone("R5 read");
    check(rdData == expData, "R5", "read data", rdData, expData);
    afterDone();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqRead = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqData = '0;
    repeat (4) @(negedge clk);
    check(csN && !busy && !done && !shStart, "R1", "reset state",
          {csN, busy, done, shStart}, 4'b1000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && !busy && !shStart, "R1", "idle after reset", {csN, busy, shStart}, 3'b100);

    // R2 R3 R4: device idle, one status frame
    doWrite(16'h1234, 8'h5A, 2);
    // R2: device busy for two polls, three status frames
    doWrite(16'h1235, 8'hC3, 0);
    // R5: reads, no polling even right after a write
    doRead(16'h1234, 8'h5A);
    doRead(16'h1235, 8'hC3);
    doRead(16'hBEEF, 8'hFF);
    doWrite(16'hFF00, 8'h00, 5);
    doWrite(16'h00FF, 8'h81, 1);
    doRead(16'hFF00, 8'h00);
    doRead(16'h00FF, 8'h81);

    // R10: both strobes together, write wins
    pushWriteFrames(16'h0042, 8'h77, 0);
    pulseReq(1'b1, 1'b1, 16'h0042, 8'h77);
    waitDone("R10 both strobes");
    afterDone();
    doRead(16'h0042, 8'h77);

    // R8: strobes during busy are ignored
    pushWriteFrames(16'h0100, 8'h11, 0);
    pulseReq(1'b0, 1'b1, 16'h0100, 8'h11);
    repeat (10) @(negedge clk);
    reqRead = 1'b1; reqAddr = 16'h0200;
    @(negedge clk);
    reqRead = 1'b0; reqWrite = 1'b1; reqAddr = 16'h0300; reqData = 8'hEE;
    @(negedge clk);
    reqWrite = 1'b0;
    waitDone("R8 write with stray strobes");
    check(rdData == 8'h77, "R8", "rdData unchanged by ignored read", rdData, 8'h77);
    afterDone();
    doRead(16'h0300, 8'hFF);
    doRead(16'h0100, 8'h11);

    repeat (2 * GUARD + 4) @(negedge clk);
    check(expQ.size() == 0, "R2", "all expected frames seen", expQ.size(), 0);
    check(csN && !busy, "R1", "idle at end", {csN, busy}, 2'b10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule